// File: doc/BRIEF.md
# Non-Overlapping Two-Phase Clock Generator

This block turns a line-locked master rate into a pair of processor clock phases whose high intervals are always separated by a guaranteed quiet gap. It runs from a fast system clock. The master clock is modelled as a single-cycle tick produced every `DIV_50HZ` or `DIV_60HZ` system cycles, and a select input picks which of the two rates applies. Each master tick ends the phase that is currently high. Both phases then stay low for exactly `DEAD_CYC` system cycles before the opposite phase rises. The phases therefore toggle at half the master rate, as antiphase square waves separated by dead time.

A hold input stretches the clock while a slow peripheral bus transfer is in progress. While hold is asserted at a master tick, the phase that is high stays high and the other stays low. The first tick seen with hold released ends the stretched phase.

The sequencer is a five-state machine:
- `ST_IDLE`: the reset state, with both phases low.
- `ST_GAP1`: dead time before phase 1 rises.
- `ST_PH1`: phase 1 high.
- `ST_GAP2`: dead time before phase 2 rises.
- `ST_PH2`: phase 2 high.

The transitions are:
- start: `ST_IDLE`→`ST_GAP1` on a tick with hold low.
- rise1: `ST_GAP1`→`ST_PH1` when the dead timer expires.
- end1: `ST_PH1`→`ST_GAP2` on a tick with hold low.
- rise2: `ST_GAP2`→`ST_PH2` when the dead timer expires.
- end2: `ST_PH2`→`ST_GAP1` on a tick with hold low.

Ticks that arrive during a gap state have no effect. For this reason the master period must exceed `DEAD_CYC + 1` system cycles.

Top module: `twophase_clkgen`

## Requirements
- R1: `phi1` and `phi2` are never high in the same system clock cycle.
- R2: Every rising edge of either phase is preceded by exactly `DEAD_CYC` cycles (default 2) in which both phases are low.
- R3: The phases alternate strictly, and the first phase to rise after reset is `phi1`.
- R4: While `rst_n` is low, both phases are low. After release, `phi1` is first high at the sample taken L+`DEAD_CYC` cycles later, where L is the master period.
- R5: The master period L is `DIV_50HZ` (default 19) system cycles when `line_sel`=0 and `DIV_60HZ` (default 16) when `line_sel`=1. With hold low and `line_sel` stable, each high interval lasts L−`DEAD_CYC` cycles.
- R6: When `bus_hold` is high at a clock edge, a phase that was high before that edge is still high after it, and the other phase is still low.
- R7: After `bus_hold` returns low, a phase held high falls within L cycles, at the next master tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_sel | input | 1 | Line-rate select: 0 selects the 50 Hz master period, 1 selects the 60 Hz period |
| bus_hold | input | 1 | Peripheral bus transfer in progress; freezes the phase sequence |
| phi1 | output | 1 | Processor clock phase 1 |
| phi2 | output | 1 | Processor clock phase 2 |

## Verification
The hardest case to reach is a hold that is high in exactly the cycle of a master tick while a phase is high. Only that alignment shows whether the falling edge is suppressed and then released on the next tick. A line-select change part-way through a master count, which shortens one period, is similarly hard to reach. The stimulus reaches both with a long run of random hold bursts of 1 to 40 cycles and occasional random `line_sel` flips. The random run is preceded by directed reset-release runs at both rates and one long hold placed on `phi2`.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_GAP1 = 3'd1,
        ST_PH1  = 3'd2,
        ST_GAP2 = 3'd3,
        ST_PH2  = 3'd4
    } tpc_state_e;
endpackage

// File: rtl/tpc_tick_gen.sv
// Master clock model: one-cycle tick every DIV_A (sel=0) or DIV_B (sel=1) cycles.
module tpc_tick_gen #(
    parameter int DIV_A = 19,
    parameter int DIV_B = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    output logic tick
);
    localparam int MAXD = (DIV_A > DIV_B) ? DIV_A : DIV_B;
    localparam int W    = $clog2(MAXD + 1);

    logic [W-1:0] cnt_q;
    logic [W-1:0] lim;

    always_comb begin
        lim  = sel ? W'(DIV_B) : W'(DIV_A);
        // ">=" lets a switch to the shorter period wrap at once
        tick = (cnt_q >= (lim - W'(1)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + W'(1);
        end
    end
endmodule

// File: rtl/tpc_dead_timer.sv
// Counts gap cycles while run is high; expired marks the last gap cycle.
module tpc_dead_timer #(
    parameter int DEAD_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = (DEAD_CYC > 1) ? $clog2(DEAD_CYC) : 1;

    logic [CW-1:0] cnt_q;

    always_comb begin
        expired = run && (cnt_q == CW'(DEAD_CYC - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (run && !expired) begin
            cnt_q <= cnt_q + CW'(1);
        end else begin
            cnt_q <= '0;
        end
    end
endmodule

// File: rtl/tpc_phase_fsm.sv
module tpc_phase_fsm
    import tpc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic hold,
    input  logic gap_done,
    output logic gap_run,
    output logic phi1,
    output logic phi2
);
    tpc_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (tick && !hold) state_d = ST_GAP1;  // start
            ST_GAP1: if (gap_done)      state_d = ST_PH1;   // rise1
            ST_PH1:  if (tick && !hold) state_d = ST_GAP2;  // end1
            ST_GAP2: if (gap_done)      state_d = ST_PH2;   // rise2
            ST_PH2:  if (tick && !hold) state_d = ST_GAP1;  // end2
            default:                    state_d = ST_IDLE;
        endcase
    end

    // Moore outputs decoded from the state register only
    always_comb begin
        phi1    = (state_q == ST_PH1);
        phi2    = (state_q == ST_PH2);
        gap_run = (state_q == ST_GAP1) || (state_q == ST_GAP2);
    end
endmodule

// File: rtl/twophase_clkgen.sv
module twophase_clkgen #(
    parameter int DEAD_CYC = 2,
    parameter int DIV_50HZ = 19,
    parameter int DIV_60HZ = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_sel,
    input  logic bus_hold,
    output logic phi1,
    output logic phi2
);
    logic mtick;
    logic gap_run;
    logic gap_done;

    tpc_tick_gen #(
        .DIV_A(DIV_50HZ),
        .DIV_B(DIV_60HZ)
    ) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .sel  (line_sel),
        .tick (mtick)
    );

    tpc_dead_timer #(
        .DEAD_CYC(DEAD_CYC)
    ) u_dead (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (gap_run),
        .expired(gap_done)
    );

    tpc_phase_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (mtick),
        .hold    (bus_hold),
        .gap_done(gap_done),
        .gap_run (gap_run),
        .phi1    (phi1),
        .phi2    (phi2)
    );
endmodule

// File: rtl/tpc_checker.sv
module tpc_checker #(
    parameter int DEAD_CYC = 2
) (
    input logic clk,
    input logic rst_n,
    input logic bus_hold,
    input logic phi1,
    input logic phi2
);
    int   low_run;
    logic last_was_p1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run     <= 0;
            last_was_p1 <= 1'b0;
        end else begin
            if (phi1 || phi2)
                low_run <= 0;
            else if (low_run < DEAD_CYC)
                low_run <= low_run + 1;
            if (phi1)
                last_was_p1 <= 1'b1;
            else if (phi2)
                last_was_p1 <= 1'b0;
        end
    end

    assert_no_overlap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(phi1 && phi2));

    assert_gap_before_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(phi1) || $rose(phi2)) |-> (low_run >= DEAD_CYC));

    assert_p1_alternates_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phi1) |-> !last_was_p1);

    assert_p2_alternates_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phi2) |-> last_was_p1);

    assert_hold_keeps_p1_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (phi1 && bus_hold) |=> (phi1 && !phi2));

    assert_hold_keeps_p2_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (phi2 && bus_hold) |=> (phi2 && !phi1));

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_low_R4: assert (!phi1 && !phi2);
        end
    end
endmodule

bind twophase_clkgen tpc_checker #(.DEAD_CYC(DEAD_CYC)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_hold(bus_hold),
    .phi1    (phi1),
    .phi2    (phi2)
);

// File: tb/sim_twophase_clkgen.sv
module sim_twophase_clkgen;
    localparam int DEAD = 2;
    localparam int D50  = 19;
    localparam int D60  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_sel = 1'b0;
    logic bus_hold = 1'b0;
    logic phi1, phi2;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    twophase_clkgen #(.DEAD_CYC(DEAD), .DIV_50HZ(D50), .DIV_60HZ(D60)) u0 (
        .clk(clk), .rst_n(rst_n), .line_sel(line_sel), .bus_hold(bus_hold),
        .phi1(phi1), .phi2(phi2)
    );

    function automatic int lim_of(logic s);
        return s ? D60 : D50;
    endfunction

    function automatic int exp_width(logic s);
        return lim_of(s) - DEAD;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- per-cycle monitor (samples at negedge) ----------------
    logic prev_p1 = 1'b0, prev_p2 = 1'b0, prev_sel = 1'b0, prev_hold = 1'b0;
    int   low_cnt = 0, high_cnt = 0, last_high = 0, pend_cnt = 0;
    bit   seen_fall = 1'b0, clean = 1'b0, pend = 1'b0;

    always @(negedge clk) begin
        if (!rst_n) begin
            check(!phi1 && !phi2, "R4", "phases during reset", {phi1, phi2}, 0);
            prev_p1 = 1'b0; prev_p2 = 1'b0; low_cnt = 0; high_cnt = 0;
            last_high = 0; seen_fall = 1'b0; clean = 1'b0; pend = 1'b0;
        end else begin
            check(!(phi1 && phi2), "R1", "overlap", {phi1, phi2}, 0);
            if (bus_hold && prev_p1)
                check(phi1 && !phi2, "R6", "p1 held", {phi1, phi2}, 2);
            if (bus_hold && prev_p2)
                check(phi2 && !phi1, "R6", "p2 held", {phi1, phi2}, 1);
            if (bus_hold || (line_sel != prev_sel))
                clean = 1'b0;
            if (bus_hold)
                pend = 1'b0;

            if ((phi1 && !prev_p1) || (phi2 && !prev_p2)) begin
                if (seen_fall)
                    check(low_cnt == DEAD, "R2", "dead cycles", low_cnt, DEAD);
                if (phi1) begin
                    check(last_high != 1, "R3", "p1 rise after p1", last_high, 2);
                    last_high = 1;
                end else begin
                    check(last_high == 1, "R3", "p2 rise order", last_high, 1);
                    last_high = 2;
                end
                high_cnt = 1;
            end else if ((!phi1 && prev_p1) || (!phi2 && prev_p2)) begin
                if (clean && seen_fall)
                    check(high_cnt == exp_width(line_sel), "R5", "high width",
                          high_cnt, exp_width(line_sel));
                if (pend) begin
                    pend_cnt++;
                    check(pend_cnt <= D50, "R7", "resume delay", pend_cnt, D50);
                    pend = 1'b0;
                end
                seen_fall = 1'b1;
                clean = 1'b1;
                low_cnt = 1;
            end else begin
                if (phi1 || phi2) high_cnt++;
                else low_cnt++;
                if (pend) pend_cnt++;
            end

            if (prev_hold && !bus_hold && (phi1 || phi2)) begin
                pend = 1'b1;
                pend_cnt = 0;
            end
            prev_p1 = phi1;
            prev_p2 = phi2;
        end
        prev_sel = line_sel;
        prev_hold = bus_hold;
    end

    // ---------------- stimulus ----------------
    task automatic reset_run(logic sel);
        int k;
        @(negedge clk); #1;
        rst_n = 1'b0; line_sel = sel; bus_hold = 1'b0;
        repeat (4) @(negedge clk);
        #1 rst_n = 1'b1;
        k = 0;
        forever begin
            @(negedge clk);
            k++;
            if (phi2) begin
                check(1'b0, "R3", "phi2 rose first", k, 0);
                break;
            end
            if (phi1 || k > 200) break;
        end
        // R4: first phi1 high at L + DEAD
        check(k == lim_of(sel) + DEAD, "R4", "first phi1 rise cycle", k, lim_of(sel) + DEAD);
    endtask

    initial begin
        int k;
        int hold_left;
        void'($urandom(32'd20240611));

        reset_run(1'b0);
        repeat (100) @(negedge clk);
        reset_run(1'b1);

        // directed long hold on phi2 (R6, R7)
        k = 0;
        while (!phi2 && k < 100) begin @(negedge clk); k++; end
        #1 bus_hold = 1'b1;
        repeat (60) @(negedge clk);
        check(phi2 && !phi1, "R6", "phi2 after 60 held cycles", {phi1, phi2}, 1);
        #1 bus_hold = 1'b0;
        k = 0;
        while (phi2 && k < 100) begin @(negedge clk); k++; end
        check(k <= D60, "R7", "phi2 release delay", k, D60);

        // random phase: hold bursts and occasional rate switch
        hold_left = 0;
        for (int i = 0; i < 40000; i++) begin
            @(negedge clk); #1;
            if (hold_left > 0) begin
                hold_left--;
                bus_hold = (hold_left != 0);
            end else if ($urandom % 60 == 0) begin
                hold_left = 1 + ($urandom % 40);
                bus_hold = 1'b1;
            end else begin
                bus_hold = 1'b0;
            end
            if ($urandom % 3000 == 0) line_sel = ~line_sel;
        end
        #1 bus_hold = 1'b0;
        repeat (50) @(negedge clk);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule